// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block turns one master clock into a family of clock-enable strobes for a bank of PWM channels. A free-running binary prescaler produces eleven taps: the undivided rate and the master rate divided by 2, 4, 8 and so on up to 1024. Every output is a single-cycle enable pulse in the master-clock domain. No output is a derived clock.

Two independent linear dividers, A and B, each pick one prescaler tap through a 4-bit select field. Each divides that tap's pulse rate by an 8-bit integer and drives `clka_en` or `clkb_en`. A divisor of zero switches the divider off, and the divisor and select fields of both dividers clear to zero on reset. Each channel has a 4-bit selector that routes one tap, clkA or clkB to that channel's enable output.

A power-management gate input stops the divided strobes without a reset. When the gate is low, the prescaler returns to its starting count and only the undivided strobe stays asserted.

Top module: `pwm_clkgen_top`

## Requirements
- R1: `tap_en[0]` is always 1. For k from 1 to 10, `tap_en[k]` is high for exactly one cycle in every 2^k cycles while the gate is high. Counting from the first gated-on cycle (the cycle after reset is released, or the cycle after `mclk_en` returns high) as cycle 1, the pulse falls on cycle 2^k and on every multiple of it.
- R2: While `rst` is high, and one cycle after it, `tap_en[10:1]`, `clka_en`, `clkb_en` and every `ch_en` bit are low. Reset clears both dividers' divisor fields and select fields to 0, so both dividers stay off until they are written.
- R3: While `mclk_en` is low, `tap_en[10:1]`, `clka_en` and `clkb_en` are low on the following cycle and `tap_en[0]` stays 1. The prescaler restarts its count when the gate returns high.
- R4: A divider counts the pulses of its selected tap. Select code s, for s from 0 to 10, picks the tap with ratio 2^s. On the selected tap's pulse in which its count equals DIV-1, it emits a one-cycle pulse in the same cycle as that tap pulse, then wraps its count to 0. The output rate is therefore the tap rate divided by DIV, and DIV=1 passes every tap pulse.
- R5: With a divisor field of 0, that divider's output stays low.
- R6: Select codes 11 to 15 keep that divider's output low.
- R7: A write (`a_wr` or `b_wr`) loads both fields and clears that divider's count. A tap pulse in the write cycle is neither counted nor forwarded, so the first output comes on the DIV-th selected pulse after the write.
- R8: Each channel's 4-bit code routes a source to that channel's `ch_en` bit in the same cycle as the source. Codes 0 to 10 select `tap_en[code]`, code 11 selects clkA and code 12 selects clkB. Codes 13 to 15 give 0.
- R9: Divider B behaves as R4 to R7 describe with its own fields, independently of divider A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Power-management gate; low stops the divided strobes |
| a_wr | input | 1 | Write strobe for divider A fields |
| a_div | input | 8 | Divisor for A (0 = off) |
| a_sel | input | 4 | Tap select for A (0..10, others off) |
| b_wr | input | 1 | Write strobe for divider B fields |
| b_div | input | 8 | Divisor for B (0 = off) |
| b_sel | input | 4 | Tap select for B (0..10, others off) |
| ch_sel | input | 16 | Four 4-bit channel codes; channel i uses bits [4i+3:4i] |
| tap_en | output | 11 | Prescaler strobes; bit k pulses at 1/2^k |
| clka_en | output | 1 | Divider A strobe |
| clkb_en | output | 1 | Divider B strobe |
| ch_en | output | 4 | Per-channel selected strobe |

## Verification
The hardest states to reach from the ports are the slow ones: the 1/1024 tap, and a divider wrapping on a slow tap. Both require long stretches with the gate high and no reset. A single low gate cycle resets the prescaler, and a write clears the divider count, so these states are easily cut short. The stimulus therefore mixes random phases with frequent gate drops and field writes, and a dedicated run of more than two thousand gated-on cycles that starts from a forced prescaler restart. Small divisors on fast taps exercise the wrap repeatedly within that budget, and a cycle model in the bench follows every strobe.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
  localparam int TAP_NUM = 11;
  localparam int CODE_W  = 4;
  localparam int CODE_A  = 11;
  localparam int CODE_B  = 12;
endpackage

// File: rtl/pwm_prescaler.sv
// Binary prescaler: comb strobes for the next edge, registered tap outputs.
module pwm_prescaler #(
  parameter int TAPS = pwm_clkgen_pkg::TAP_NUM
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  output logic [TAPS-1:0] strobe,
  output logic [TAPS-1:0] tap_q
);
  localparam int CW = TAPS - 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!run) cnt <= '0;
    else      cnt <= cnt + 1'b1;
  end

  assign strobe[0] = run;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign strobe[k] = run && (&cnt[k-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) tap_q <= {{CW{1'b0}}, 1'b1};
    else     tap_q <= {strobe[TAPS-1:1], 1'b1};
  end
endmodule

// File: rtl/pwm_lin_div.sv
// Linear divider over one selectable prescaler strobe.
module pwm_lin_div #(
  parameter int TAPS  = pwm_clkgen_pkg::TAP_NUM,
  parameter int DIV_W = 8,
  parameter int SEL_W = pwm_clkgen_pkg::CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [DIV_W-1:0] div_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [TAPS-1:0]  strobe,
  output logic             pulse_nxt,
  output logic             pulse_q
);
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             pick, armed, hit;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < TAPS; i++)
      if (sel_q == SEL_W'(i)) pick = strobe[i];
  end

  assign armed     = pick && (div_q != '0);
  assign hit       = armed && (cnt_q == div_q - 1'b1);
  assign pulse_nxt = hit && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_nxt;
      if (wr) begin
        div_q <= div_in;
        sel_q <= sel_in;
        cnt_q <= '0;
      end else if (armed) begin
        cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_mux.sv
// One channel's strobe selector, registered in step with its sources.
module pwm_chan_mux #(
  parameter int TAPS  = pwm_clkgen_pkg::TAP_NUM,
  parameter int SEL_W = pwm_clkgen_pkg::CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] code,
  input  logic [TAPS-1:0]  tap_nxt,
  input  logic             a_nxt,
  input  logic             b_nxt,
  output logic             en_q
);
  logic nxt;

  always_comb begin
    nxt = 1'b0;
    for (int i = 0; i < TAPS; i++)
      if (code == SEL_W'(i)) nxt = tap_nxt[i];
    if (code == SEL_W'(pwm_clkgen_pkg::CODE_A)) nxt = a_nxt;
    if (code == SEL_W'(pwm_clkgen_pkg::CODE_B)) nxt = b_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= nxt;
  end
endmodule

// File: rtl/pwm_clkgen_top.sv
module pwm_clkgen_top #(
  parameter int TAPS   = pwm_clkgen_pkg::TAP_NUM,
  parameter int DIV_W  = 8,
  parameter int SEL_W  = pwm_clkgen_pkg::CODE_W,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mclk_en,
  input  logic                    a_wr,
  input  logic [DIV_W-1:0]        a_div,
  input  logic [SEL_W-1:0]        a_sel,
  input  logic                    b_wr,
  input  logic [DIV_W-1:0]        b_div,
  input  logic [SEL_W-1:0]        b_sel,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  output logic [TAPS-1:0]         tap_en,
  output logic                    clka_en,
  output logic                    clkb_en,
  output logic [NUM_CH-1:0]       ch_en
);
  logic            run;
  logic [TAPS-1:0] strobe, tap_nxt;
  logic            a_nxt, b_nxt;

  assign run     = mclk_en && !rst;
  assign tap_nxt = {strobe[TAPS-1:1], 1'b1};

  pwm_prescaler #(.TAPS(TAPS)) u_pre (
    .clk(clk), .rst(rst), .run(run), .strobe(strobe), .tap_q(tap_en)
  );

  pwm_lin_div #(.TAPS(TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_div_a (
    .clk(clk), .rst(rst), .wr(a_wr), .div_in(a_div), .sel_in(a_sel),
    .strobe(strobe), .pulse_nxt(a_nxt), .pulse_q(clka_en)
  );

  pwm_lin_div #(.TAPS(TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_div_b (
    .clk(clk), .rst(rst), .wr(b_wr), .div_in(b_div), .sel_in(b_sel),
    .strobe(strobe), .pulse_nxt(b_nxt), .pulse_q(clkb_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan_mux #(.TAPS(TAPS), .SEL_W(SEL_W)) u_mux (
      .clk(clk), .rst(rst), .code(ch_sel[c*SEL_W +: SEL_W]),
      .tap_nxt(tap_nxt), .a_nxt(a_nxt), .b_nxt(b_nxt), .en_q(ch_en[c])
    );
  end
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
  parameter int TAPS   = 11,
  parameter int DIV_W  = 8,
  parameter int SEL_W  = 4,
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mclk_en,
  input logic                    a_wr,
  input logic [DIV_W-1:0]        a_div,
  input logic [SEL_W-1:0]        a_sel,
  input logic                    b_wr,
  input logic [DIV_W-1:0]        b_div,
  input logic [SEL_W-1:0]        b_sel,
  input logic [NUM_CH*SEL_W-1:0] ch_sel,
  input logic [TAPS-1:0]         tap_en,
  input logic                    clka_en,
  input logic                    clkb_en,
  input logic [NUM_CH-1:0]       ch_en
);
  assert_tap0_R1: assert property (@(posedge clk) disable iff (rst) tap_en[0]);

  assert_tap1_alt_R1: assert property (@(posedge clk) disable iff (rst)
    tap_en[1] |=> !tap_en[1]);

  for (genvar k = 2; k < TAPS; k++) begin : g_nest
    assert_tap_nest_R1: assert property (@(posedge clk) disable iff (rst)
      tap_en[k] |-> tap_en[k-1]);
  end

  assert_reset_R2: assert property (@(posedge clk)
    rst |=> (tap_en[TAPS-1:1] == '0 && !clka_en && !clkb_en && ch_en == '0));

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !mclk_en |=> (tap_en[TAPS-1:1] == '0 && !clka_en && !clkb_en && tap_en[0]));

  assert_div_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (a_wr && a_div == '0) |=> !clka_en ##1 !clka_en);

  assert_sel_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
    (a_wr && a_sel >= SEL_W'(TAPS)) |=> !clka_en ##1 !clka_en);

  assert_wr_a_R7: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> !clka_en);

  assert_wr_b_R9: assert property (@(posedge clk) disable iff (rst)
    (b_wr && (b_div == '0 || b_sel >= SEL_W'(TAPS))) |=> !clkb_en ##1 !clkb_en);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_ch_off_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_sel[c*SEL_W +: SEL_W] > SEL_W'(TAPS + 1)) |=> !ch_en[c]);
  end
endmodule

bind pwm_clkgen_top pwm_clkgen_chk #(
  .TAPS(TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst(rst), .mclk_en(mclk_en),
  .a_wr(a_wr), .a_div(a_div), .a_sel(a_sel),
  .b_wr(b_wr), .b_div(b_div), .b_sel(b_sel),
  .ch_sel(ch_sel), .tap_en(tap_en), .clka_en(clka_en),
  .clkb_en(clkb_en), .ch_en(ch_en)
);

// File: tb/pwm_clkgen_top_tb_top.sv
`timescale 1ns/1ps
module pwm_clkgen_top_tb_top;
  localparam int TAPS = 11, DIV_W = 8, SEL_W = 4, NUM_CH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, mclk_en = 1'b1;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [DIV_W-1:0] a_div = '0, b_div = '0;
  logic [SEL_W-1:0] a_sel = '0, b_sel = '0;
  logic [NUM_CH*SEL_W-1:0] ch_sel = '0;
  logic [TAPS-1:0] tap_en;
  logic clka_en, clkb_en;
  logic [NUM_CH-1:0] ch_en;

  always #10 clk = ~clk;

  pwm_clkgen_top #(.TAPS(TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .mclk_en(mclk_en),
    .a_wr(a_wr), .a_div(a_div), .a_sel(a_sel),
    .b_wr(b_wr), .b_div(b_div), .b_sel(b_sel),
    .ch_sel(ch_sel), .tap_en(tap_en), .clka_en(clka_en),
    .clkb_en(clkb_en), .ch_en(ch_en)
  );

  int checks = 0, errors = 0;
  int m = 0;
  int ad = 0, as_ = 0, ac = 0, bd = 0, bs = 0, bc = 0;
  logic [TAPS-1:0] e_tap;
  logic e_a, e_b;
  logic [NUM_CH-1:0] e_ch;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic pick_of(input int sel, input logic run, input logic [TAPS-1:0] t);
    if (sel == 0) return run;
    if (sel < TAPS) return t[sel];
    return 1'b0;
  endfunction

  task automatic div_model(ref int d, ref int s, ref int c, output logic o,
                           input logic wr, input int wd, input int ws,
                           input logic run, input logic [TAPS-1:0] t);
    o = 1'b0;
    if (rst) begin d = 0; s = 0; c = 0; end
    else if (wr) begin d = wd; s = ws; c = 0; end
    else if (pick_of(s, run, t) && d != 0) begin
      o = (c == d - 1);
      c = o ? 0 : c + 1;
    end
  endtask

  // One clock: model the edge from current inputs, then compare at negedge.
  task automatic step();
    logic run;
    string treq;
    run = !rst && mclk_en;
    e_tap[0] = 1'b1;
    for (int k = 1; k < TAPS; k++)
      e_tap[k] = run && (((m + 1) & ((1 << k) - 1)) == 0);
    m = run ? m + 1 : 0;
    div_model(ad, as_, ac, e_a, a_wr, int'(a_div), int'(a_sel), run, e_tap);
    div_model(bd, bs, bc, e_b, b_wr, int'(b_div), int'(b_sel), run, e_tap);
    for (int c = 0; c < NUM_CH; c++) begin
      int code;
      code = int'(ch_sel[c*SEL_W +: SEL_W]);
      if (rst) e_ch[c] = 1'b0;
      else if (code < TAPS) e_ch[c] = e_tap[code];
      else if (code == 11) e_ch[c] = e_a;
      else if (code == 12) e_ch[c] = e_b;
      else e_ch[c] = 1'b0;
    end
    treq = rst ? "R2" : (!mclk_en ? "R3" : "R1");
    @(posedge clk);
    @(negedge clk);
    check(tap_en === e_tap, treq, "tap_en", tap_en, e_tap);
    check(clka_en === e_a, rst ? "R2" : "R4", "clka_en", clka_en, e_a);
    check(clkb_en === e_b, rst ? "R2" : "R9", "clkb_en", clkb_en, e_b);
    check(ch_en === e_ch, rst ? "R2" : "R8", "ch_en", ch_en, e_ch);
    a_wr = 1'b0;
    b_wr = 1'b0;
  endtask

  task automatic write_a(input int d, input int s);
    a_div = DIV_W'(d); a_sel = SEL_W'(s); a_wr = 1'b1; step();
  endtask

  task automatic write_b(input int d, input int s);
    b_div = DIV_W'(d); b_sel = SEL_W'(s); b_wr = 1'b1; step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n3, na, nb, n10;
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    // R2: reset state
    repeat (3) step();
    check(tap_en[0] === 1'b1 && clka_en === 1'b0 && ch_en === '0, "R2", "reset outputs",
          {tap_en, clka_en, ch_en}, {11'h001, 1'b0, 4'h0});
    rst = 1'b0;

    // R4: A on tap 3 divided by 5
    write_a(5, 3);
    n3 = 0; na = 0;
    repeat (400) begin step(); n3 += tap_en[3]; na += clka_en; end
    check(na == n3 / 5, "R4", "clkA count on tap3/5", na, n3 / 5);

    // R9 / R4: B on undivided tap, divisor 1
    write_b(1, 0);
    nb = 0;
    repeat (50) begin step(); nb += clkb_en; end
    check(nb == 50, "R9", "clkB count div1", nb, 50);

    // R5: divisor zero; R6: reserved select
    write_a(0, 1);
    write_b(1, 13);
    na = 0; nb = 0;
    repeat (100) begin step(); na += clka_en; nb += clkb_en; end
    check(na == 0, "R5", "clkA with div 0", na, 0);
    check(nb == 0, "R6", "clkB with select 13", nb, 0);

    // R7: rewrite mid-count, first pulse on the third pulse after the write
    write_a(10, 0);
    repeat (4) step();
    write_a(3, 0);
    step(); check(clka_en === 1'b0, "R7", "pulse 1 after write", clka_en, 0);
    step(); check(clka_en === 1'b0, "R7", "pulse 2 after write", clka_en, 0);
    step(); check(clka_en === 1'b1, "R7", "pulse 3 after write", clka_en, 1);

    // R8: channel routing, including unused codes
    write_b(2, 1);
    ch_sel = {4'd12, 4'd11, 4'd2, 4'd0};
    repeat (40) step();
    ch_sel = {4'd15, 4'd14, 4'd13, 4'd13};
    na = 0;
    repeat (20) begin step(); na += $countones(ch_en); end
    check(na == 0, "R8", "codes 13..15 give no enable", na, 0);

    // R3: gate off then restart
    mclk_en = 1'b0;
    repeat (20) step();
    check(tap_en === 11'h001, "R3", "taps while gated", tap_en, 11'h001);
    mclk_en = 1'b1;
    step(); check(tap_en[1] === 1'b0, "R3", "tap1 first run cycle", tap_en[1], 0);
    step(); check(tap_en[1] === 1'b1, "R3", "tap1 second run cycle", tap_en[1], 1);

    // Random phase
    repeat (3000) begin
      mclk_en = ($urandom % 20) != 0;
      rst = ($urandom % 500) == 0;
      if (($urandom % 40) == 0) begin
        a_wr = 1'b1;
        a_div = (($urandom % 10) == 0) ? DIV_W'($urandom) : DIV_W'($urandom % 6);
        a_sel = (($urandom % 4) == 0) ? SEL_W'($urandom) : SEL_W'($urandom % 4);
      end
      if (($urandom % 40) == 0) begin
        b_wr = 1'b1;
        b_div = DIV_W'($urandom % 6);
        b_sel = (($urandom % 4) == 0) ? SEL_W'($urandom) : SEL_W'($urandom % 4);
      end
      if (($urandom % 30) == 0) ch_sel = NUM_CH*SEL_W'($urandom);
      step();
    end
    rst = 1'b0;

    // R1: long gated-on stretch reaching the slowest tap
    mclk_en = 1'b0; step();
    mclk_en = 1'b1;
    n10 = 0;
    repeat (2100) begin step(); n10 += tap_en[10]; end
    check(n10 == 2, "R1", "tap10 pulses in 2100 cycles", n10, 2);

    finish_run();
  end
endmodule